// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Cache

This block caches virtual-to-physical page translations for a processor that uses 8 KB pages. A 32-bit virtual address therefore splits into a 13-bit page offset and a 19-bit virtual page number. A 30-bit physical address splits into the same offset and a 17-bit physical page number. Any slot may hold any page. Each slot also stores an 8-bit process identifier, so translations of several address spaces can live side by side and a context switch only changes the current-process input. A lookup presents a virtual page number. One clock later the block returns hit or miss together with the physical page number, the permission bits and the dirty bit.

On a miss, the page-table walk happens outside the block, and the resulting translation comes back through the refill port. The refill is written into a slot chosen in this order:
- a slot that already holds the same page for the same process is overwritten;
- otherwise the lowest-numbered empty slot is used;
- otherwise a pseudo-random slot is chosen, skipping the slot of the most recent hit.

Two flush inputs are available. One empties the whole table. The other removes only the entries of one process.

Lookups use a valid/ready handshake. The block lowers `lk_ready` for the cycle in which either flush input is high, so a lookup offered in that cycle waits until the next one. Responses cannot be stalled: `rsp_valid` pulses for exactly one cycle, one clock after each accepted lookup, and the consumer must take it then. The refill and flush pins are plain control inputs with no handshake.

Top module: `tlb_xlate_cache`

## Requirements
- R1: After reset every slot is empty, `rsp_valid` is low, `lk_ready` is high, and any lookup misses.
- R2: A lookup hits when some slot is valid, its stored page number equals `lk_vpn`, and its stored process identifier equals `cur_pid`. The response one cycle later then carries that slot's physical page number, permission bits and dirty bit.
- R3: A slot whose page number matches but whose process identifier differs from `cur_pid` does not produce a hit.
- R4: A miss response has `rsp_hit`=0 and all-zero `rsp_ppn`, `rsp_perm` and `rsp_dirty`.
- R5: While the table has an empty slot, a refill of a new page fills an empty slot (lowest index first) and evicts no valid entry.
- R6: A refill whose page number and process identifier equal those of a valid slot overwrites that slot, so no two slots can ever match the same lookup.
- R7: When the table is full, a refill of a new page evicts exactly one entry, chosen pseudo-randomly, and never the entry used by the most recent hit.
- R8: `flush_all` empties every slot; lookups in later cycles miss.
- R9: `flush_pid_en` empties exactly the valid slots whose process identifier equals `flush_pid` and leaves all other slots intact.
- R10: A lookup in the same cycle as a refill sees the contents from before the refill; the refilled entry is visible to lookups from the next cycle on.
- R11: While either flush input is high, `lk_ready` is low and a refill presented in that cycle is dropped.
- R12: `rsp_valid` is high for exactly one cycle, one clock after each cycle with `lk_valid` and `lk_ready` both high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_pid | input | 8 | Process identifier of the running context, used for lookups |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_vpn | input | 19 | Virtual page number to translate |
| rsp_valid | output | 1 | Lookup result present (one-cycle pulse) |
| rsp_hit | output | 1 | Result is a hit |
| rsp_ppn | output | 17 | Physical page number on a hit, zero on a miss |
| rsp_perm | output | 3 | Permission bits on a hit, zero on a miss |
| rsp_dirty | output | 1 | Dirty bit on a hit, zero on a miss |
| fill_valid | input | 1 | Refill entry present this cycle |
| fill_vpn | input | 19 | Refill virtual page number |
| fill_pid | input | 8 | Refill process identifier |
| fill_ppn | input | 17 | Refill physical page number |
| fill_perm | input | 3 | Refill permission bits |
| fill_dirty | input | 1 | Refill dirty bit |
| flush_all | input | 1 | Empty the whole table |
| flush_pid_en | input | 1 | Empty the entries of one process |
| flush_pid | input | 8 | Process whose entries are emptied |

## Verification
The tag match is tried with the same page under two process identifiers, with an unmapped page, and with a page mapped only for another process. These cases separate a comparison that ignores the process field from one that is correct. An overwrite of an existing page shows whether duplicates get created, and a lookup issued together with a refill shows which contents a lookup sees. With the table full, the bench repeatedly hits one resident page and then refills a new one. It counts how many known pages still hit, which must be exactly the depth, and it confirms that the recently hit page survived; this tests victim choice without predicting the random sequence. Whole-table and per-process flushes are each followed by lookups of pages that must be removed and of pages that must survive.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Which rule chose the slot for a refill
  typedef enum logic [1:0] {
    VSRC_MATCH = 2'd0,
    VSRC_FREE  = 2'd1,
    VSRC_RAND  = 2'd2
  } vsrc_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  // One step of a maximal-length Galois shift register
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ LFSR_TAPS;
    return n;
  endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
  import tlb_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] state
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= lfsr_step(state);
  end

  // The random source must never lock up at zero (supports R7)
  p_lfsr_alive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned VPN_W = 19,
  parameter int unsigned PID_W = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]            ent_valid,
  input  logic [DEPTH-1:0][VPN_W-1:0] ent_vpn,
  input  logic [DEPTH-1:0][PID_W-1:0] ent_pid,
  input  logic [VPN_W-1:0]            key_vpn,
  input  logic [PID_W-1:0]            key_pid,
  output logic [DEPTH-1:0]            match_vec,
  output logic                        match_any,
  output logic [IDX_W-1:0]            match_idx
);

  // Per-slot comparator
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) && (ent_pid[g] == key_pid);
  end

  assign match_any = |match_vec;

  // Encode the matching slot. At most one slot matches, so an OR of the
  // indices of all matching slots gives the index.
  always_comb begin
    match_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_vec[i]) match_idx = match_idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]  ent_valid,
  input  logic              dup_hit,
  input  logic [IDX_W-1:0]  dup_idx,
  input  logic [LFSR_W-1:0] rnd,
  input  logic              mru_valid,
  input  logic [IDX_W-1:0]  mru_idx,
  output logic [IDX_W-1:0]  victim_idx,
  output vsrc_e             victim_src
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic             any_free;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] rnd_idx;
  logic [IDX_W-1:0] rnd_adj;

  // Lowest-numbered empty slot
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  // Random slot, stepped past the most recently hit one
  always_comb begin
    rnd_idx = IDX_W'(rnd % LFSR_W'(DEPTH));
    rnd_adj = rnd_idx;
    if (mru_valid && (rnd_idx == mru_idx)) begin
      rnd_adj = (rnd_idx == LAST_IDX) ? '0 : rnd_idx + IDX_W'(1);
    end
  end

  always_comb begin
    if (dup_hit) begin
      victim_idx = dup_idx;
      victim_src = VSRC_MATCH;
    end else if (any_free) begin
      victim_idx = free_idx;
      victim_src = VSRC_FREE;
    end else begin
      victim_idx = rnd_adj;
      victim_src = VSRC_RAND;
    end
  end

endmodule

// File: rtl/tlb_xlate_cache.sv
module tlb_xlate_cache
  import tlb_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned VPN_W  = 19,
  parameter int unsigned PPN_W  = 17,
  parameter int unsigned PID_W  = 8,
  parameter int unsigned PERM_W = 3,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PID_W-1:0]  cur_pid,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PERM_W-1:0] rsp_perm,
  output logic              rsp_dirty,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PID_W-1:0]  fill_pid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              fill_dirty,
  input  logic              flush_all,
  input  logic              flush_pid_en,
  input  logic [PID_W-1:0]  flush_pid
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // ---------------- entry storage ----------------
  logic [DEPTH-1:0]             ent_valid;
  logic [DEPTH-1:0][VPN_W-1:0]  ent_vpn;
  logic [DEPTH-1:0][PID_W-1:0]  ent_pid;
  logic [DEPTH-1:0][PPN_W-1:0]  ent_ppn;
  logic [DEPTH-1:0][PERM_W-1:0] ent_perm;
  logic [DEPTH-1:0]             ent_dirty;

  // ---------------- control ----------------
  logic             any_flush;
  logic             accept;
  logic             fill_ok;
  logic [DEPTH-1:0] lk_vec;
  logic             lk_hit;
  logic [IDX_W-1:0] lk_idx;
  logic [DEPTH-1:0] dup_vec;
  logic             dup_hit;
  logic [IDX_W-1:0] dup_idx;
  logic [LFSR_W-1:0] rnd;
  logic             mru_valid;
  logic [IDX_W-1:0] mru_idx;
  logic [IDX_W-1:0] victim_idx;
  vsrc_e            victim_src;

  assign any_flush = flush_all | flush_pid_en;
  assign lk_ready  = !any_flush;
  assign accept    = lk_valid && lk_ready;
  assign fill_ok   = fill_valid && !any_flush;

  // Lookup comparator array
  tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PID_W(PID_W)) u_lk_cam (
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_pid   (ent_pid),
    .key_vpn   (lk_vpn),
    .key_pid   (cur_pid),
    .match_vec (lk_vec),
    .match_any (lk_hit),
    .match_idx (lk_idx)
  );

  // Refill duplicate detector
  tlb_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PID_W(PID_W)) u_dup_cam (
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_pid   (ent_pid),
    .key_vpn   (fill_vpn),
    .key_pid   (fill_pid),
    .match_vec (dup_vec),
    .match_any (dup_hit),
    .match_idx (dup_idx)
  );

  tlb_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (rnd)
  );

  tlb_victim #(.DEPTH(DEPTH)) u_victim (
    .ent_valid  (ent_valid),
    .dup_hit    (dup_hit),
    .dup_idx    (dup_idx),
    .rnd        (rnd),
    .mru_valid  (mru_valid),
    .mru_idx    (mru_idx),
    .victim_idx (victim_idx),
    .victim_src (victim_src)
  );

  // ---------------- per-slot update ----------------
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel;
    assign sel = fill_ok && (victim_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
      end else if (flush_all) begin
        ent_valid[g] <= 1'b0;
      end else if (flush_pid_en && (ent_pid[g] == flush_pid)) begin
        ent_valid[g] <= 1'b0;
      end else if (sel) begin
        ent_valid[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_vpn[g]   <= fill_vpn;
        ent_pid[g]   <= fill_pid;
        ent_ppn[g]   <= fill_ppn;
        ent_perm[g]  <= fill_perm;
        ent_dirty[g] <= fill_dirty;
      end
    end
  end

  // ---------------- most recent hit ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mru_valid <= 1'b0;
      mru_idx   <= '0;
    end else if (accept && lk_hit) begin
      mru_valid <= 1'b1;
      mru_idx   <= lk_idx;
    end
  end

  // ---------------- response register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
      rsp_dirty <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept && lk_hit) begin
        rsp_hit   <= 1'b1;
        rsp_ppn   <= ent_ppn[lk_idx];
        rsp_perm  <= ent_perm[lk_idx];
        rsp_dirty <= ent_dirty[lk_idx];
      end else begin
        rsp_hit   <= 1'b0;
        rsp_ppn   <= '0;
        rsp_perm  <= '0;
        rsp_dirty <= 1'b0;
      end
    end
  end

  // ---------------- checks ----------------
  // State kept after a per-process flush, for the checks that follow it
  logic             fpid_chk_q;
  logic [PID_W-1:0] fpid_q;
  logic [DEPTH-1:0] keep_q;
  logic [DEPTH-1:0] flushed_pid_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fpid_chk_q <= 1'b0;
      fpid_q     <= '0;
      keep_q     <= '0;
    end else begin
      fpid_chk_q <= flush_pid_en && !flush_all;
      fpid_q     <= flush_pid;
      for (int i = 0; i < DEPTH; i++) begin
        keep_q[i] <= ent_valid[i] && (ent_pid[i] != flush_pid);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      flushed_pid_vec[i] = ent_valid[i] && (ent_pid[i] == fpid_q);
    end
  end

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  p_rsp_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !rsp_valid);
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == '0 && !rsp_dirty));
  p_hit_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_vec) && $onehot0(dup_vec));
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (ent_valid == '0));
  p_pid_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fpid_chk_q |-> (flushed_pid_vec == '0));
  p_pid_spared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fpid_chk_q |-> ((ent_valid & keep_q) == keep_q));
  p_free_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && !dup_hit && !(&ent_valid)) |-> !ent_valid[victim_idx]);
  p_spare_mru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && victim_src == VSRC_RAND && mru_valid) |-> (victim_idx != mru_idx));
  p_fill_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |=> ent_valid[$past(victim_idx)]);
  p_flush_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && any_flush) |=> !rsp_valid);

endmodule

// File: tb/tlb_xlate_cache_bench.sv
module tlb_xlate_cache_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cur_pid = '0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [18:0] lk_vpn = '0;
  logic        rsp_valid, rsp_hit, rsp_dirty;
  logic [16:0] rsp_ppn;
  logic [2:0]  rsp_perm;
  logic        fill_valid = 1'b0;
  logic [18:0] fill_vpn = '0;
  logic [7:0]  fill_pid = '0;
  logic [16:0] fill_ppn = '0;
  logic [2:0]  fill_perm = '0;
  logic        fill_dirty = 1'b0;
  logic        flush_all = 1'b0;
  logic        flush_pid_en = 1'b0;
  logic [7:0]  flush_pid = '0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tlb_xlate_cache u_tlb_xlate_cache (
    .clk, .rst_n, .cur_pid, .lk_valid, .lk_ready, .lk_vpn,
    .rsp_valid, .rsp_hit, .rsp_ppn, .rsp_perm, .rsp_dirty,
    .fill_valid, .fill_vpn, .fill_pid, .fill_ppn, .fill_perm, .fill_dirty,
    .flush_all, .flush_pid_en, .flush_pid
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic lookup(input logic [18:0] vpn, input logic [7:0] pid, output logic hit,
                        output logic [16:0] ppn, output logic [2:0] perm, output logic dirty);
    lk_valid = 1'b1; lk_vpn = vpn; cur_pid = pid;
    @(negedge clk);
    lk_valid = 1'b0;
    check(rsp_valid === 1'b1, "R12 rsp_valid after accepted lookup", 32'(rsp_valid), 1);
    hit = rsp_hit; ppn = rsp_ppn; perm = rsp_perm; dirty = rsp_dirty;
  endtask

  task automatic refill(input logic [18:0] vpn, input logic [7:0] pid, input logic [16:0] ppn,
                        input logic [2:0] perm, input logic dirty);
    fill_valid = 1'b1; fill_vpn = vpn; fill_pid = pid;
    fill_ppn = ppn; fill_perm = perm; fill_dirty = dirty;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [18:0] vpn, input logic [7:0] pid, input logic exp, input string req);
    logic h, d; logic [16:0] p; logic [2:0] m;
    lookup(vpn, pid, h, p, m, d);
    check(h === exp, req, 32'(h), 32'(exp));
  endtask

  // op: 1 = refill, 2 = lookup with expected result in ppn/perm/dirty/exp_hit
  typedef struct packed {
    logic [1:0]  op;
    logic [18:0] vpn;
    logic [7:0]  pid;
    logic [16:0] ppn;
    logic [2:0]  perm;
    logic        dirty;
    logic        exp_hit;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 19'h00100, 8'd1, 17'h000AA, 3'd5, 1'b1, 1'b0},
    '{2'd1, 19'h00200, 8'd1, 17'h000BB, 3'd3, 1'b0, 1'b0},
    '{2'd1, 19'h00100, 8'd2, 17'h000CC, 3'd1, 1'b0, 1'b0},
    '{2'd2, 19'h00100, 8'd1, 17'h000AA, 3'd5, 1'b1, 1'b1},  // R2
    '{2'd2, 19'h00100, 8'd2, 17'h000CC, 3'd1, 1'b0, 1'b1},  // R2 other process
    '{2'd2, 19'h00200, 8'd2, 17'h00000, 3'd0, 1'b0, 1'b0},  // R3 pid mismatch
    '{2'd2, 19'h00300, 8'd1, 17'h00000, 3'd0, 1'b0, 1'b0},  // R4 unmapped
    '{2'd1, 19'h00100, 8'd1, 17'h000DD, 3'd6, 1'b0, 1'b0},  // R6 overwrite
    '{2'd2, 19'h00100, 8'd1, 17'h000DD, 3'd6, 1'b0, 1'b1},  // R6 new data
    '{2'd2, 19'h00200, 8'd1, 17'h000BB, 3'd3, 1'b0, 1'b1}   // R6 neighbour kept
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic h, d; logic [16:0] p; logic [2:0] m;
    logic resident [16];
    int hits;
    int x;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 0);
    check(lk_ready === 1'b1, "R1 lk_ready after reset", 32'(lk_ready), 1);
    expect_hit(19'h00100, 8'd1, 1'b0, "R1 empty table misses");

    // Table of vectors
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].op == 2'd1) begin
        refill(VECS[i].vpn, VECS[i].pid, VECS[i].ppn, VECS[i].perm, VECS[i].dirty);
      end else begin
        lookup(VECS[i].vpn, VECS[i].pid, h, p, m, d);
        check(h === VECS[i].exp_hit, $sformatf("R2/R3 hit vec %0d", i), 32'(h), 32'(VECS[i].exp_hit));
        check(p === VECS[i].ppn, $sformatf("R2/R4 ppn vec %0d", i), 32'(p), 32'(VECS[i].ppn));
        check(m === VECS[i].perm && d === VECS[i].dirty, $sformatf("R2/R4 perm,dirty vec %0d", i),
              32'({m, d}), 32'({VECS[i].perm, VECS[i].dirty}));
      end
    end

    // R12: no lookup offered, so no response
    @(negedge clk);
    check(rsp_valid === 1'b0, "R12 rsp_valid idle", 32'(rsp_valid), 0);

    // R10: lookup together with refill sees old contents
    fill_valid = 1'b1; fill_vpn = 19'h00400; fill_pid = 8'd1;
    fill_ppn = 17'h00044; fill_perm = 3'd7; fill_dirty = 1'b1;
    lk_valid = 1'b1; lk_vpn = 19'h00400; cur_pid = 8'd1;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_hit === 1'b0, "R10 same-cycle lookup misses", 32'(rsp_hit), 0);
    lookup(19'h00400, 8'd1, h, p, m, d);
    check(h === 1'b1 && p === 17'h00044, "R10 refill visible next cycle", 32'(p), 32'h44);

    // R9 and R11: per-process flush with a refill offered alongside
    flush_pid_en = 1'b1; flush_pid = 8'd2;
    fill_valid = 1'b1; fill_vpn = 19'h00500; fill_pid = 8'd1; fill_ppn = 17'h00055;
    lk_valid = 1'b1; lk_vpn = 19'h00100; cur_pid = 8'd1;
    #1;
    check(lk_ready === 1'b0, "R11 lk_ready low during flush", 32'(lk_ready), 0);
    @(negedge clk);
    flush_pid_en = 1'b0; fill_valid = 1'b0;
    check(rsp_valid === 1'b0, "R11 lookup held during flush", 32'(rsp_valid), 0);
    @(negedge clk);
    lk_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_hit === 1'b1, "R11 held lookup completes after flush", 32'(rsp_hit), 1);
    expect_hit(19'h00500, 8'd1, 1'b0, "R11 refill during flush dropped");
    expect_hit(19'h00100, 8'd2, 1'b0, "R9 flushed process entry gone");
    expect_hit(19'h00100, 8'd1, 1'b1, "R9 other process entry kept");
    expect_hit(19'h00200, 8'd1, 1'b1, "R9 other process entry kept (2)");

    // R8: flush everything
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
    expect_hit(19'h00100, 8'd1, 1'b0, "R8 flush_all clears");
    expect_hit(19'h00200, 8'd1, 1'b0, "R8 flush_all clears (2)");
    expect_hit(19'h00400, 8'd1, 1'b0, "R8 flush_all clears (3)");

    // R5: fill all eight slots, all must remain
    for (int i = 0; i < 8; i++) refill(19'h00010 + 19'(i), 8'd3, 17'h00100 + 17'(i), 3'd1, 1'b0);
    hits = 0;
    for (int i = 0; i < 8; i++) begin
      lookup(19'h00010 + 19'(i), 8'd3, h, p, m, d);
      if (h) hits++;
      resident[i] = h;
    end
    check(hits == 8, "R5 free slots filled without eviction", 32'(hits), 8);

    // R7: with the table full, recently hit entry survives, exactly one evicted
    for (int it = 0; it < 8; it++) begin
      x = 0;
      for (int j = 0; j < 8 + it; j++) if (resident[j]) x = j;
      lookup(19'h00010 + 19'(x), 8'd3, h, p, m, d);
      check(h === 1'b1, "R7 chosen resident hits", 32'(h), 1);
      refill(19'h00010 + 19'(8 + it), 8'd3, 17'h00100 + 17'(8 + it), 3'd1, 1'b0);
      lookup(19'h00010 + 19'(x), 8'd3, h, p, m, d);
      check(h === 1'b1, "R7 most recent hit not evicted", 32'(h), 1);
      hits = 0;
      for (int j = 0; j < 9 + it; j++) begin
        lookup(19'h00010 + 19'(j), 8'd3, h, p, m, d);
        resident[j] = h;
        if (h) hits++;
      end
      check(hits == 8, "R7 exactly one entry evicted", 32'(hits), 8);
      check(resident[8 + it] === 1'b1, "R7 new entry resident", 32'(resident[8 + it]), 1);
    end

    // R1: reset again empties the table
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_hit(19'h00017, 8'd3, 1'b0, "R1 reset empties table");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule